// File: doc/BRIEF.md
# Multi-Mode Feedback Divider for a Frequency Synthesizer

This block divides a local-oscillator pulse stream by a programmable ratio. It emits one strobe per completed division period, and that strobe feeds the feedback side of a phase comparator. Two oscillator streams arrive as single-cycle strobes that are already synchronized to the system clock: a high-band stream and a low-band stream.

A band-select bit and a path-select bit pick one of three arrangements:

- **High band:** a divide-by-two prescaler ahead of a 16-bit counter. The overall ratio is twice the programmed word.
- **Low band, wide counter:** the low-band stream drives the 16-bit counter directly.
- **Low band, narrow counter:** the low-band stream drives a 12-bit direct counter. Only the low 12 bits of the word are used.

Mode and divisor are sampled while reset is held, and again at every terminal count. A change made in the middle of a period therefore never alters that period. A divisor below the floor of its mode is raised to that floor. The same event sets an error flag that stays set until a legal divisor is loaded or reset is applied.

Top module: `lo_feedback_divider`

## Requirements
- R1: While `rst` is high, `divStrobe` and `divErr` are 0, all counters and the prescaler phase are cleared, and the mode and divisor present on the inputs are taken as the first period's setting.
- R2: With `bandSel`=1 (the value of `pathSel` does not matter), one strobe is produced per 2×N high-band edges, where N is the loaded divisor word (272..65535).
- R3: With `bandSel`=0 and `pathSel`=1, one strobe is produced per N low-band edges, with N in 272..65535.
- R4: With `bandSel`=0 and `pathSel`=0, one strobe is produced per N low-band edges, where N is `divWord[11:0]` (4..4095) and bits 15:12 have no effect.
- R5: The stream not chosen by the active mode does not advance the count. In the high-band mode, low-band edges are ignored. In both low-band modes, high-band edges are ignored.
- R6: `divStrobe` is one clock wide and rises in the cycle after the clock in which the period's last counted edge arrives.
- R7: A change of mode or divisor takes effect only at the next terminal count. The period in progress keeps its length.
- R8: In the 16-bit modes, a loaded word below 272 is used as 272 and sets `divErr`.
- R9: In the 12-bit mode, a loaded 12-bit value below 4 is used as 4 and sets `divErr`.
- R10: `divErr` changes only when a divisor is loaded at a terminal count. It stays 1 while illegal words keep being loaded, and returns to 0 when a legal word is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hiEdge | input | 1 | One-cycle strobe per high-band oscillator edge |
| loEdge | input | 1 | One-cycle strobe per low-band oscillator edge |
| bandSel | input | 1 | 1 selects the high band with prescaler; 0 selects the low band |
| pathSel | input | 1 | In the low band: 1 selects the 16-bit counter, 0 selects the 12-bit counter |
| divWord | input | 16 | Programmed division word |
| divStrobe | output | 1 | One-cycle strobe per completed division period |
| divErr | output | 1 | Sticky flag: the last loaded divisor was below its mode's floor |

## Verification
The checker takes for granted that the edge strobes come from an already synchronized source, that each is high for at most one clock per edge, and that reset is held at the first clock. On those assumptions it requires:

- strobes are spaced by at least four clocks, since the smallest period is four edges;
- every strobe is preceded by an input edge;
- the error flag moves only together with a strobe.

The stimulus keeps within these assumptions by driving each stream as one-cycle pulses chosen per cycle, and by starting every run under reset. Mode and divisor changes arrive at arbitrary points within a period, including words below the floor and 12-bit-mode words whose upper bits are set.

// File: rtl/lo_div_pkg.sv
package lo_div_pkg;

  typedef enum logic [1:0] {
    MODE_NARROW    = 2'd0,
    MODE_WIDE_LO   = 2'd1,
    MODE_WIDE_HI   = 2'd2
  } divMode_e;

  // Counting strobes from control to datapath
  typedef struct packed {
    logic tickWide;
    logic tickNarrow;
  } divCmd_t;

endpackage

// File: rtl/lo_div_ctrl.sv
module lo_div_ctrl
  import lo_div_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int NARROW_W   = 12,
  parameter int WIDE_MIN   = 272,
  parameter int NARROW_MIN = 4,
  parameter int PRE_W      = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hiEdge,
  input  logic                loEdge,
  input  logic                bandSel,
  input  logic                pathSel,
  input  logic [WORD_W-1:0]   divWord,
  input  logic                terminal,
  output divCmd_t             cmd,
  output logic [WORD_W-1:0]   wideLimit,
  output logic [NARROW_W-1:0] narrowLimit,
  output logic                divErr
);

  localparam logic [WORD_W-1:0]   WIDE_FLOOR   = WORD_W'(WIDE_MIN);
  localparam logic [NARROW_W-1:0] NARROW_FLOOR = NARROW_W'(NARROW_MIN);

  divMode_e            actMode;
  divMode_e            reqMode;
  logic [WORD_W-1:0]   reqWide;
  logic [NARROW_W-1:0] reqNarrow;
  logic [NARROW_W-1:0] wordLow;
  logic                wideBad;
  logic                narrowBad;
  logic                reqBad;
  logic                preWrap;
  logic                tickSel;

  // Requested setting, decoded and clamped
  always_comb begin
    if (bandSel)      reqMode = MODE_WIDE_HI;
    else if (pathSel) reqMode = MODE_WIDE_LO;
    else              reqMode = MODE_NARROW;
    wordLow   = divWord[NARROW_W-1:0];
    wideBad   = divWord < WIDE_FLOOR;
    narrowBad = wordLow < NARROW_FLOOR;
    reqWide   = wideBad ? WIDE_FLOOR : divWord;
    reqNarrow = narrowBad ? NARROW_FLOOR : wordLow;
    reqBad    = (reqMode == MODE_NARROW) ? narrowBad : wideBad;
  end

  // Prescaler ahead of the wide counter on the high band
  generate
    if (PRE_W > 0) begin : g_pre
      logic [PRE_W-1:0] preCnt;
      assign preWrap = &preCnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          preCnt <= '0;
        end else if (terminal) begin
          preCnt <= '0;
        end else if (hiEdge && actMode == MODE_WIDE_HI) begin
          preCnt <= preCnt + 1'b1;
        end
      end
    end else begin : g_nopre
      assign preWrap = 1'b1;
    end
  endgenerate

  always_comb begin
    if (actMode == MODE_WIDE_HI) tickSel = hiEdge && preWrap;
    else                         tickSel = loEdge;
    cmd.tickWide   = tickSel && (actMode != MODE_NARROW);
    cmd.tickNarrow = tickSel && (actMode == MODE_NARROW);
  end

  // Active setting: loaded under reset and at each terminal count
  always_ff @(posedge clk) begin
    if (rst) begin
      actMode     <= reqMode;
      wideLimit   <= reqWide;
      narrowLimit <= reqNarrow;
      divErr      <= 1'b0;
    end else if (terminal) begin
      actMode     <= reqMode;
      wideLimit   <= reqWide;
      narrowLimit <= reqNarrow;
      divErr      <= reqBad;
    end
  end

endmodule

// File: rtl/lo_div_count.sv
module lo_div_count
  import lo_div_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  divCmd_t             cmd,
  input  logic [WORD_W-1:0]   wideLimit,
  input  logic [NARROW_W-1:0] narrowLimit,
  output logic                terminal,
  output logic                divStrobe
);

  logic [WORD_W-1:0]   wideCnt;
  logic [NARROW_W-1:0] narrowCnt;
  logic                wideEnd;
  logic                narrowEnd;

  assign wideEnd   = cmd.tickWide   && (wideCnt   == wideLimit   - 1'b1);
  assign narrowEnd = cmd.tickNarrow && (narrowCnt == narrowLimit - 1'b1);
  assign terminal  = wideEnd || narrowEnd;

  always_ff @(posedge clk) begin
    if (rst || terminal) begin
      wideCnt <= '0;
    end else if (cmd.tickWide) begin
      wideCnt <= wideCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || terminal) begin
      narrowCnt <= '0;
    end else if (cmd.tickNarrow) begin
      narrowCnt <= narrowCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) divStrobe <= 1'b0;
    else     divStrobe <= terminal;
  end

endmodule

// File: rtl/lo_feedback_divider.sv
module lo_feedback_divider
  import lo_div_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int NARROW_W   = 12,
  parameter int WIDE_MIN   = 272,
  parameter int NARROW_MIN = 4,
  parameter int PRE_W      = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hiEdge,
  input  logic              loEdge,
  input  logic              bandSel,
  input  logic              pathSel,
  input  logic [WORD_W-1:0] divWord,
  output logic              divStrobe,
  output logic              divErr
);

  divCmd_t             cmd;
  logic                terminal;
  logic [WORD_W-1:0]   wideLimit;
  logic [NARROW_W-1:0] narrowLimit;

  lo_div_ctrl #(
    .WORD_W(WORD_W), .NARROW_W(NARROW_W), .WIDE_MIN(WIDE_MIN),
    .NARROW_MIN(NARROW_MIN), .PRE_W(PRE_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .hiEdge(hiEdge), .loEdge(loEdge),
    .bandSel(bandSel), .pathSel(pathSel), .divWord(divWord),
    .terminal(terminal), .cmd(cmd), .wideLimit(wideLimit),
    .narrowLimit(narrowLimit), .divErr(divErr)
  );

  lo_div_count #(
    .WORD_W(WORD_W), .NARROW_W(NARROW_W)
  ) u_count (
    .clk(clk), .rst(rst), .cmd(cmd), .wideLimit(wideLimit),
    .narrowLimit(narrowLimit), .terminal(terminal), .divStrobe(divStrobe)
  );

endmodule

// File: rtl/lo_div_checker.sv
module lo_div_checker (
  input logic clk,
  input logic rst,
  input logic hiEdge,
  input logic loEdge,
  input logic divStrobe,
  input logic divErr
);

  // R1: outputs quiet in the cycle after a reset clock
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!divStrobe && !divErr));

  // R6: single-cycle strobe
  assert_strobe_width_R6: assert property (@(posedge clk) disable iff (rst)
    divStrobe |=> !divStrobe);

  // R6: a strobe follows a cycle carrying an input edge
  assert_strobe_after_edge_R6: assert property (@(posedge clk) disable iff (rst)
    divStrobe |-> $past(hiEdge || loEdge));

  // R9: smallest period is four edges, so strobes are at least four clocks apart
  assert_min_spacing_R9: assert property (@(posedge clk) disable iff (rst)
    divStrobe |-> (!$past(divStrobe, 1) && !$past(divStrobe, 2) && !$past(divStrobe, 3)));

  // R10: the error flag moves only with a terminal count
  assert_err_at_load_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(divErr) |-> divStrobe);

endmodule

bind lo_feedback_divider lo_div_checker u_chk (
  .clk(clk), .rst(rst), .hiEdge(hiEdge), .loEdge(loEdge),
  .divStrobe(divStrobe), .divErr(divErr)
);

// File: tb/lo_feedback_divider_tb.sv
module lo_feedback_divider_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hiEdge = 1'b0;
  logic        loEdge = 1'b0;
  logic        bandSel = 1'b0;
  logic        pathSel = 1'b1;
  logic [15:0] divWord = 16'd280;
  logic        divStrobe;
  logic        divErr;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  int mMode = 1;
  int mLim = 280;
  int mCnt = 0;
  int mPh = 0;
  bit mErr = 0;
  bit mStb = 0;
  bit prevStb = 0;

  lo_feedback_divider u_dut (
    .clk(clk), .rst(rst), .hiEdge(hiEdge), .loEdge(loEdge),
    .bandSel(bandSel), .pathSel(pathSel), .divWord(divWord),
    .divStrobe(divStrobe), .divErr(divErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int modeOf(logic b, logic p);
    return b ? 2 : (p ? 1 : 0);
  endfunction

  function automatic int limitOf(int m, logic [15:0] w);
    int v;
    if (m == 0) begin
      v = int'(w[11:0]);
      return (v < 4) ? 4 : v;
    end
    v = int'(w);
    return (v < 272) ? 272 : v;
  endfunction

  function automatic bit badOf(int m, logic [15:0] w);
    if (m == 0) return int'(w[11:0]) < 4;
    return int'(w) < 272;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit h, bit l);
    int  prevMode;
    bit  tick;
    string tag;
    hiEdge = h;
    loEdge = l;
    prevMode = mMode;
    if (rst) begin
      mMode = modeOf(bandSel, pathSel);
      mLim  = limitOf(mMode, divWord);
      mErr = 0; mCnt = 0; mPh = 0; mStb = 0;
    end else begin
      tick = 0;
      if (mMode == 2) begin
        if (h) begin
          if (mPh == 1) tick = 1;
          mPh = 1 - mPh;
        end
      end else begin
        tick = l;
      end
      mStb = 0;
      if (tick) begin
        if (mCnt == mLim - 1) begin
          mStb = 1; mCnt = 0; mPh = 0;
          mMode = modeOf(bandSel, pathSel);
          mLim  = limitOf(mMode, divWord);
          mErr  = badOf(mMode, divWord);
        end else begin
          mCnt++;
        end
      end
    end
    @(posedge clk);
    #1;
    tag = (prevMode == 2) ? "R2" : ((prevMode == 1) ? "R3" : "R4");
    check(divStrobe === mStb, tag, "divStrobe", int'(divStrobe), int'(mStb));
    check(divErr === mErr, "R10", "divErr", int'(divErr), int'(mErr));
    check(!(prevStb && divStrobe), "R6", "back-to-back strobe", int'(divStrobe), 0);
    prevStb = divStrobe;
    @(negedge clk);
  endtask

  task automatic countEdges(bit useHi, output int n);
    n = 0;
    do begin
      if (useHi) step(1'b1, 1'($urandom % 2));
      else       step(1'($urandom % 2), 1'b1);
      n++;
    end while (!prevStb && n < 20000);
  endtask

  task automatic doReset();
    rst = 1'b1;
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int n;
    int strobes;
    void'($urandom(32'd4711));
    @(negedge clk);

    // R1: reset state
    bandSel = 0; pathSel = 1; divWord = 16'd280;
    doReset();
    check(divStrobe === 1'b0 && divErr === 1'b0, "R1", "outputs after reset",
          int'(divStrobe) + int'(divErr), 0);

    // R3: low band, wide counter
    countEdges(0, n);
    check(n == 280, "R3", "low-band wide period", n, 280);

    // R7: mid-period change
    repeat (100) step(1'b0, 1'b1);
    divWord = 16'd300;
    countEdges(0, n);
    check(n == 180, "R7", "remainder of old period", n, 180);
    countEdges(0, n);
    check(n == 300, "R7", "first period with new word", n, 300);

    // R8 / R10: below floor in 16-bit mode
    divWord = 16'd10;
    countEdges(0, n);
    check(n == 300, "R7", "period before illegal word", n, 300);
    check(divErr === 1'b1, "R8", "error after low wide word", int'(divErr), 1);
    countEdges(0, n);
    check(n == 272, "R8", "clamped wide period", n, 272);
    check(divErr === 1'b1, "R10", "error sticky", int'(divErr), 1);
    divWord = 16'd280;
    countEdges(0, n);
    check(n == 272, "R8", "clamped period again", n, 272);
    check(divErr === 1'b0, "R10", "error cleared by legal word", int'(divErr), 0);

    // R9: narrow counter below floor
    pathSel = 0; divWord = 16'd2;
    countEdges(0, n);
    check(n == 280, "R7", "wide period before narrow switch", n, 280);
    check(divErr === 1'b1, "R9", "error after low narrow word", int'(divErr), 1);
    countEdges(0, n);
    check(n == 4, "R9", "clamped narrow period", n, 4);

    // R4: upper bits ignored in narrow mode
    divWord = 16'hF005;
    countEdges(0, n);
    check(n == 4, "R9", "clamped period before new word", n, 4);
    check(divErr === 1'b0, "R10", "legal narrow word clears error", int'(divErr), 0);
    countEdges(0, n);
    check(n == 5, "R4", "narrow period ignoring upper bits", n, 5);

    // R5: high-band edges ignored in low band
    strobes = 0;
    for (int i = 0; i < 60; i++) begin
      step(1'b1, 1'b0);
      if (prevStb) strobes++;
    end
    check(strobes == 0, "R5", "strobes from high edges in low band", strobes, 0);

    // R2: high band with prescaler
    bandSel = 1; pathSel = 0; divWord = 16'd300;
    countEdges(0, n);
    check(n == 5, "R7", "narrow period before band switch", n, 5);
    strobes = 0;
    for (int i = 0; i < 100; i++) begin
      step(1'b0, 1'b1);
      if (prevStb) strobes++;
    end
    check(strobes == 0, "R5", "strobes from low edges in high band", strobes, 0);
    countEdges(1, n);
    check(n == 600, "R2", "high-band period", n, 600);

    // R1: mid-period reset restarts from the new setting
    repeat (50) step(1'b1, 1'b0);
    bandSel = 0; pathSel = 1; divWord = 16'd290;
    doReset();
    check(divStrobe === 1'b0 && divErr === 1'b0, "R1", "outputs after mid reset",
          int'(divStrobe) + int'(divErr), 0);
    countEdges(0, n);
    check(n == 290, "R1", "period after mid reset", n, 290);

    // Constrained random segments
    for (int seg = 0; seg < 18; seg++) begin
      int dens;
      bandSel = 1'($urandom % 3 == 0);
      pathSel = 1'($urandom % 2);
      if (!bandSel && !pathSel) begin
        divWord = {4'($urandom), 12'(1 + $urandom % 40)};
      end else if ($urandom % 5 == 0) begin
        divWord = 16'(200 + $urandom % 72);
      end else begin
        divWord = 16'(272 + $urandom % 64);
      end
      dens = 1 + $urandom % 3;
      for (int c = 0; c < 3000; c++) begin
        step(1'($urandom % 4 < dens), 1'($urandom % 4 < dens));
      end
      if (seg == 9) doReset();
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule